// File: doc/BRIEF.md
# Eight-bit compare timer

This block is an up-counter that advances by one on each cycle where the `tick` strobe is high. A control field picks one of two counting modes. In free-running mode the counter wraps from all-ones to zero. In clear-on-match mode, compare register A acts as a variable top, and the counter returns to zero on the tick after it equals that value. Two compare channels, A and B, watch the counter. When a channel matches, it sets its own sticky flag and applies a 2-bit action to its output pin. A third sticky flag records the counter passing all-ones. Each flag reaches its interrupt line through its own enable bit.

Software reaches the block through a single-cycle register port. A write is a cycle with `wr_en` high, and a read returns the value at `addr` combinationally on `rdata`. Through this port it can load the counter, set both compare values and the control field, clear flags, set the interrupt mask, or fire a channel's pin action at once without a match.

The counter core has a two-state machine. State `CNT_RUN` is the normal state. In it, a counter write takes transition `LOAD_SUPPRESS` to state `CNT_SUPPRESS`, and any other cycle takes `STAY_RUN`. In `CNT_SUPPRESS`, compare matches are ignored. A counter write there keeps the state (`RELOAD`). The next advancing tick takes `RESUME` back to `CNT_RUN`. A cycle with neither keeps the state (`WAIT`).

Top module: `cmp_timer8`

## Requirements
- R1: After reset, every register reads 0 and both pins and all three interrupt lines are low.
- R2: In free-running mode (control bit 0 = 0), each tick adds one to the counter, and 0xFF is followed by 0x00. Without a tick the counter holds.
- R3: In clear-on-match mode (control bit 0 = 1), a tick while the counter equals compare A loads 0 instead of the increment.
- R4: The overflow flag (flag bit 0) is set by a tick taken at 0xFF, in either mode. In clear-on-match mode with compare A below 0xFF it is never set.
- R5: A match applies the channel's output action. The action fields are control bits 2:1 for A and bits 4:3 for B. Code 00 holds the pin low, 01 inverts it, 10 drives it low and 11 drives it high.
- R6: A tick while the counter equals a channel's compare value sets that channel's sticky flag (A at flag bit 1, B at flag bit 2).
- R7: Each interrupt line is high exactly when its flag and the mask bit at the same position are both 1.
- R8: With compare A = 0, clear-on-match mode, toggle action on A and a tick every clock, pin A inverts on every clock, giving a period of two clocks.
- R9: Writing the force register (bit 0 for A, bit 1 for B) applies that channel's action on the next edge, and leaves its flag unchanged.
- R10: Writing 1 to a flag bit clears it. A flag event in the same cycle wins, and the flag ends set.
- R11: A counter write ignores a tick in the same cycle. The first tick after the write raises no compare match.
- R12: The register addresses are: control 0, force 1, counter 2, compare A 3, compare B 4, flags 5, mask 6. Force and address 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| pin_a | output | 1 | Channel A output pin |
| pin_b | output | 1 | Channel B output pin |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmpa | output | 1 | Compare A interrupt |
| irq_cmpb | output | 1 | Compare B interrupt |

## Verification
The assertions check four things on every cycle: the increment and wrap of the counter in free-running mode, the return to zero at the compare A top, the rule that any flag event leaves its flag set on the next cycle (also when a clear arrives with it), and the low idle pin. They also check that no match is raised right after a counter write.

Only the bench scenarios can show the rest. That covers the exact toggle period with compare 0, the order of actions when the mode changes from set to clear, force without a flag, and the absence of overflow in clear-on-match mode. It also covers the read map, including the reads of force and of the unused address. A behavioural model compares pins, interrupts and the read data on every clock.

// File: rtl/timer_pkg.sv
package timer_pkg;

    // Output action codes of a compare channel
    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_LOW    = 2'b10,
        OUT_HIGH   = 2'b11
    } out_mode_e;

    // Counter core state
    typedef enum logic {
        CNT_RUN      = 1'b0,
        CNT_SUPPRESS = 1'b1
    } cnt_state_e;

    localparam int ADDR_W = 3;
    localparam int NCH    = 2;
    localparam int NFLAG  = 3;
    localparam int CTRL_W = 1 + 2 * NCH;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_FORCE = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd5;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd6;

    localparam int FLAG_OVF = 0;
    localparam int FLAG_A   = 1;
    localparam int FLAG_B   = 2;

endpackage

// File: rtl/tmr_core.sv
module tmr_core
    import timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         ctc,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         adv,
    output logic         cmp_ok,
    output logic         ovf_evt
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    cnt_state_e state, state_nxt;

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            CNT_RUN:      state_nxt = load ? CNT_SUPPRESS : CNT_RUN;
            CNT_SUPPRESS: begin
                if (load)      state_nxt = CNT_SUPPRESS;
                else if (adv)  state_nxt = CNT_RUN;
                else           state_nxt = CNT_SUPPRESS;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CNT_RUN;
        else        state <= state_nxt;
    end

    // outputs of the state machine
    always_comb begin
        adv     = tick & ~load;
        cmp_ok  = 1'b0;
        unique case (state)
            CNT_RUN:      cmp_ok = adv;
            CNT_SUPPRESS: cmp_ok = 1'b0;
        endcase
        ovf_evt = adv && (cnt == CNT_MAX);
    end

    // counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (adv) begin
            if (ctc && (cnt == top)) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         cmp_ok,
    input  logic [1:0]   mode,
    input  logic         force_i,
    output logic         match_evt,
    output logic         pin
);

    out_mode_e mode_e;
    logic      fire;
    logic      pin_nxt;

    always_comb begin
        mode_e    = out_mode_e'(mode);
        match_evt = cmp_ok && (cnt == cmp);
        fire      = match_evt | force_i;
        pin_nxt   = pin;
        unique case (mode_e)
            OUT_OFF:    pin_nxt = 1'b0;
            OUT_TOGGLE: pin_nxt = fire ? ~pin : pin;
            OUT_LOW:    pin_nxt = fire ? 1'b0 : pin;
            OUT_HIGH:   pin_nxt = fire ? 1'b1 : pin;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_nxt;
    end

endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cnt,
    input  logic [NFLAG-1:0]  evt,
    output logic              ctc,
    output logic [1:0]        mode_a,
    output logic [1:0]        mode_b,
    output logic [W-1:0]      cmpa,
    output logic [W-1:0]      cmpb,
    output logic [NCH-1:0]    force_vec,
    output logic              load,
    output logic [NFLAG-1:0]  flags,
    output logic [NFLAG-1:0]  mask,
    output logic [W-1:0]      rdata
);

    logic [CTRL_W-1:0] ctrl;
    logic [NFLAG-1:0]  clr;

    assign ctc    = ctrl[0];
    assign mode_a = ctrl[2:1];
    assign mode_b = ctrl[4:3];

    always_comb begin
        load      = wr_en && (addr == A_COUNT);
        force_vec = (wr_en && (addr == A_FORCE)) ? wdata[NCH-1:0] : '0;
        clr       = (wr_en && (addr == A_FLAGS)) ? wdata[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            cmpa  <= '0;
            cmpb  <= '0;
            mask  <= '0;
            flags <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL: ctrl <= wdata[CTRL_W-1:0];
                    A_CMPA: cmpa <= wdata;
                    A_CMPB: cmpb <= wdata;
                    A_MASK: mask <= wdata[NFLAG-1:0];
                    default: ;
                endcase
            end
            flags <= evt | (flags & ~clr);
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = W'(ctrl);
            A_COUNT: rdata = cnt;
            A_CMPA:  rdata = cmpa;
            A_CMPB:  rdata = cmpb;
            A_FLAGS: rdata = W'(flags);
            A_MASK:  rdata = W'(mask);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    output logic              pin_a,
    output logic              pin_b,
    output logic              irq_ovf,
    output logic              irq_cmpa,
    output logic              irq_cmpb
);

    logic [W-1:0]     cnt;
    logic             adv;
    logic             cmp_ok;
    logic             ovf_evt;
    logic             load;
    logic             ctc;
    logic [W-1:0]     cmpa, cmpb;
    logic [1:0]       mode_a, mode_b;
    logic [NCH-1:0]   force_vec;
    logic [NCH-1:0]   match_evt;
    logic [NCH-1:0]   pin_vec;
    logic [NFLAG-1:0] evt, flags, mask, irq_vec;
    logic [W-1:0]     cmp_arr  [NCH];
    logic [1:0]       mode_arr [NCH];

    assign cmp_arr[0]  = cmpa;
    assign cmp_arr[1]  = cmpb;
    assign mode_arr[0] = mode_a;
    assign mode_arr[1] = mode_b;

    tmr_regfile #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt(cnt), .evt(evt), .ctc(ctc), .mode_a(mode_a), .mode_b(mode_b),
        .cmpa(cmpa), .cmpb(cmpb), .force_vec(force_vec), .load(load),
        .flags(flags), .mask(mask), .rdata(rdata)
    );

    tmr_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_val(wdata),
        .ctc(ctc), .top(cmpa), .cnt(cnt), .adv(adv), .cmp_ok(cmp_ok),
        .ovf_evt(ovf_evt)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        tmr_chan #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp_arr[gi]),
            .cmp_ok(cmp_ok), .mode(mode_arr[gi]), .force_i(force_vec[gi]),
            .match_evt(match_evt[gi]), .pin(pin_vec[gi])
        );
    end

    assign evt      = {match_evt[1], match_evt[0], ovf_evt};
    assign irq_vec  = flags & mask;
    assign irq_ovf  = irq_vec[FLAG_OVF];
    assign irq_cmpa = irq_vec[FLAG_A];
    assign irq_cmpb = irq_vec[FLAG_B];
    assign pin_a    = pin_vec[0];
    assign pin_b    = pin_vec[1];

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         adv,
    input logic         load,
    input logic         ctc,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmpa,
    input logic [2:0]   evt,
    input logic [2:0]   flags,
    input logic [1:0]   mode_a,
    input logic         pin_a,
    input logic         irq_cmpa
);

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ctc) |=> (cnt == ($past(cnt) + W'(1))));

    p_top_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ctc && (cnt == cmpa)) |=> (cnt == '0));

    p_ovf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> flags[0]);

    p_idle_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_a == 2'b00) && ($past(mode_a) == 2'b00)) |-> !pin_a);

    p_match_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[1] || evt[2]) |=> (flags[2:1] & $past(evt[2:1])) == $past(evt[2:1]));

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmpa |-> flags[1]);

    p_no_match_after_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!evt[1] && !evt[2]));

endmodule

bind cmp_timer8 tmr_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .ctc(ctc),
    .cnt(cnt), .cmpa(cmpa), .evt(evt), .flags(flags), .mode_a(mode_a),
    .pin_a(pin_a), .irq_cmpa(irq_cmpa)
);

// File: tb/tb_cmp_timer8.sv
module tb_cmp_timer8;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       pin_a, pin_b, irq_ovf, irq_cmpa, irq_cmpb;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 0;
    bit done   = 0;

    // reference model state
    int m_cnt = 0, m_supp = 0, m_ctrl = 0, m_cmpa = 0, m_cmpb = 0;
    int m_flags = 0, m_mask = 0;
    int m_pin [2] = '{0, 0};
    // temporaries
    int t_ld, t_adv, t_ma, t_mb, t_ov, t_frc, t_clr, t_mode, t_fire;
    int n_cnt, n_supp;

    cmp_timer8 dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b),
        .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int m_read(input int a);
        case (a)
            0: return m_ctrl;
            2: return m_cnt;
            3: return m_cmpa;
            4: return m_cmpb;
            5: return m_flags;
            6: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_supp = 0; m_ctrl = 0; m_cmpa = 0; m_cmpb = 0;
            m_flags = 0; m_mask = 0; m_pin[0] = 0; m_pin[1] = 0;
        end else begin
            t_ld  = (wr_en && addr == 3'd2) ? 1 : 0;
            t_adv = (tick && !t_ld) ? 1 : 0;
            t_ma  = (t_adv && !m_supp && m_cnt == m_cmpa) ? 1 : 0;
            t_mb  = (t_adv && !m_supp && m_cnt == m_cmpb) ? 1 : 0;
            t_ov  = (t_adv && m_cnt == 255) ? 1 : 0;
            t_frc = (wr_en && addr == 3'd1) ? int'(wdata) & 3 : 0;
            t_clr = (wr_en && addr == 3'd5) ? int'(wdata) & 7 : 0;
            if (t_ld) n_cnt = int'(wdata);
            else if (t_adv) n_cnt = ((m_ctrl & 1) && m_cnt == m_cmpa) ? 0 : (m_cnt + 1) % 256;
            else n_cnt = m_cnt;
            n_supp = t_ld ? 1 : (t_adv ? 0 : m_supp);
            for (int ch = 0; ch < 2; ch++) begin
                t_mode = (m_ctrl >> (1 + 2*ch)) & 3;
                t_fire = (ch == 0 ? t_ma : t_mb) | ((t_frc >> ch) & 1);
                if (t_mode == 0) m_pin[ch] = 0;
                else if (t_fire != 0) begin
                    if (t_mode == 1) m_pin[ch] = 1 - m_pin[ch];
                    else if (t_mode == 2) m_pin[ch] = 0;
                    else m_pin[ch] = 1;
                end
            end
            m_flags = (t_ov | (t_ma << 1) | (t_mb << 2)) | (m_flags & ~t_clr & 7);
            if (wr_en) begin
                case (addr)
                    3'd0: m_ctrl = int'(wdata) & 31;
                    3'd3: m_cmpa = int'(wdata);
                    3'd4: m_cmpb = int'(wdata);
                    3'd6: m_mask = int'(wdata) & 7;
                    default: ;
                endcase
            end
            m_cnt = n_cnt;
            m_supp = n_supp;
        end
    end

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && chk_on) begin
            check("R5 pin_a", int'(pin_a), m_pin[0]);
            check("R5 pin_b", int'(pin_b), m_pin[1]);
            check("R7 irq_ovf", int'(irq_ovf), m_flags & m_mask & 1);
            check("R7 irq_cmpa", int'(irq_cmpa), ((m_flags & m_mask) >> 1) & 1);
            check("R7 irq_cmpb", int'(irq_cmpb), ((m_flags & m_mask) >> 2) & 1);
            check("R12 rdata", int'(rdata), m_read(int'(addr)));
        end
    end

    task automatic step(input bit t, input bit we, input int a, input int d);
        @(negedge clk);
        tick = t; wr_en = we; addr = 3'(a); wdata = 8'(d);
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        tick = 0; wr_en = 0; addr = 3'(a);
        #1;
        check(tag, int'(rdata), exp);
    endtask

    task automatic after_edge;
        @(posedge clk);
        #2;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    int pv [4];

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;

        // R1 reset state
        rd(2, 0, "R1 count after reset");
        rd(5, 0, "R1 flags after reset");
        rd(0, 0, "R1 control after reset");
        check("R1 pin_a low", int'(pin_a), 0);
        check("R1 irq_ovf low", int'(irq_ovf), 0);

        // R2 counting and hold
        repeat (5) step(1, 0, 0, 0);
        rd(2, 5, "R2 count after five ticks");
        step(0, 0, 0, 0); step(0, 0, 0, 0);
        rd(2, 5, "R2 hold without tick");

        // R2/R4 wrap with overflow
        step(0, 1, 2, 8'hFD);
        repeat (3) step(1, 0, 0, 0);
        rd(2, 0, "R2 wrap to zero");
        rd(5, 7, "R4 overflow set, R6 both match flags from first tick");

        // R10 clear and priority
        step(0, 1, 5, 7);
        rd(5, 0, "R10 write-one clears");
        step(0, 1, 2, 8'hFF);
        step(1, 1, 5, 1);
        rd(5, 1, "R10 set wins over clear");
        step(0, 1, 5, 7);

        // R3 clear-on-match with top 3, toggle on A
        step(0, 1, 3, 3);
        step(0, 1, 0, 8'h03);
        step(0, 1, 2, 0);
        repeat (10) step(1, 0, 0, 0);
        rd(2, 2, "R3 count after ten ticks with top 3");
        rd(5, 6, "R4 no overflow in clear-on-match, R6 flags A and B");
        check("R5 pin_a after two toggles", int'(pin_a), 0);
        step(0, 1, 5, 7);

        // R8 two-clock period
        step(0, 1, 3, 0);
        step(0, 1, 2, 0);
        step(1, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 0, 0);
            after_edge();
            pv[k] = int'(pin_a);
        end
        check("R8 toggles each clock 0-1", int'(pv[0] != pv[1]), 1);
        check("R8 toggles each clock 1-2", int'(pv[1] != pv[2]), 1);
        check("R8 period two clocks", pv[0], pv[2]);
        check("R8 period two clocks odd", pv[1], pv[3]);

        // R5 set / clear / off on B (compare B = 0, counter sits at 0)
        step(0, 1, 0, 8'h1B);
        step(1, 0, 0, 0);
        after_edge();
        check("R5 set action drives pin_b high", int'(pin_b), 1);
        step(0, 1, 0, 8'h13);
        step(1, 0, 0, 0);
        after_edge();
        check("R5 clear action drives pin_b low", int'(pin_b), 0);
        step(0, 1, 0, 8'h1B);
        step(1, 0, 0, 0);
        after_edge();
        check("R5 set again", int'(pin_b), 1);
        step(0, 1, 0, 8'h03);
        step(0, 0, 0, 0);
        after_edge();
        check("R5 off code holds pin_b low", int'(pin_b), 0);

        // R9 force without flag
        step(0, 1, 5, 7);
        step(0, 1, 0, 8'h07);
        step(0, 1, 1, 1);
        after_edge();
        check("R9 force applies set action", int'(pin_a), 1);
        rd(5, 0, "R9 force leaves flags clear");
        step(0, 1, 0, 8'h03);
        step(0, 1, 1, 1);
        after_edge();
        check("R9 force applies toggle", int'(pin_a), 0);

        // R7 interrupt gating
        step(0, 1, 6, 7);
        step(1, 0, 0, 0);
        after_edge();
        check("R7 irq_cmpa with mask", int'(irq_cmpa), 1);
        check("R7 irq_cmpb with mask", int'(irq_cmpb), 1);
        check("R7 irq_ovf without flag", int'(irq_ovf), 0);
        step(0, 1, 6, 1);
        after_edge();
        check("R7 irq_cmpa masked off", int'(irq_cmpa), 0);
        step(0, 1, 5, 7);

        // R11 suppression after counter write
        step(0, 1, 0, 0);
        step(0, 1, 4, 8'h10);
        step(0, 1, 2, 8'h10);
        step(1, 0, 0, 0);
        rd(5, 0, "R11 no match on first tick after write");
        rd(2, 8'h11, "R11 count advanced");
        step(1, 1, 2, 8'h20);
        rd(2, 8'h20, "R11 tick ignored in write cycle");
        step(0, 1, 4, 8'h21);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        rd(5, 4, "R6 match B after suppression ends");

        // R12 read map
        step(0, 1, 0, 8'h1F);
        rd(0, 8'h1F, "R12 control readback");
        rd(1, 0, "R12 force reads zero");
        rd(6, 1, "R12 mask readback");
        rd(3, 0, "R12 compare A readback");
        rd(4, 8'h21, "R12 compare B readback");
        rd(7, 0, "R12 unused address reads zero");

        step(0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule